// File: doc/BRIEF.md
# Transport Packet PID Filter with Clock-Reference Timestamping

This block sits on a byte stream of 188-byte transport packets that can carry up to four independent transport streams, interleaved byte by byte. A stream tag goes with every byte, and a start-of-packet flag marks the first byte of each packet. For each stream the block keeps its own parse context. It decodes the three header bytes that follow the sync byte and the start of the adaptation field. It looks the 13-bit packet identifier up in a host-written table of 64 entries and forwards the payload bytes of matching, error-free packets, each tagged with the route code of the matching entry.

Each stream also has its own clock-reference identifier, set by the host. When a packet on that identifier carries a clock reference in its adaptation field, the block assembles the 42-bit value. In the cycle the last reference byte arrives, it samples the free-running 42-bit system time input. It then emits a three-beat timestamp record: first the reference, then the time sample, then the packet's slot address in its stream buffer.

Top module: `tsf_pid_pcr_filter`

## Requirements
- R1: A packet's identifier is the low 5 bits of header byte 1 (bit 12..8) followed by all of header byte 2 (bit 7..0). The packet is processed only when the identifier equals the identifier of an enabled table entry. Other bits of byte 1 do not take part in the identifier.
- R2: When more than one enabled entry holds the packet's identifier, the entry with the lowest index decides the route code. Disabling that entry hands the decision to the next matching entry.
- R3: A packet whose header byte 1 bit 7 (error flag) is 1 forwards no byte and produces no timestamp record.
- R4: The adaptation control is bits 5..4 of header byte 3. For value 01 the payload starts at byte 4. For value 11 byte 4 holds the adaptation length L and the payload starts at byte 5+L. Value 10 and value 00 carry no payload. Each payload byte of a processed packet appears on the output one cycle after it is accepted, tagged with its stream and with the entry's route code (0 video, 1 audio, 2 system). Route code 3 (clock reference only) forwards nothing.
- R5: A timestamp record is produced only when all of these hold: the identifier matches an enabled entry and equals the stream's configured clock-reference identifier, the error flag is 0, adaptation control bit 5 is 1, the length L is at least 8, and bit 4 of byte 5 (reference present) is 1.
- R6: The clock reference is taken from bytes 6..11 of the packet. The 33-bit base is bytes 6..9 followed by bit 7 of byte 10. The 6 reserved bits (byte 10 bits 6..1) are skipped. The 9-bit extension is byte 10 bit 0 followed by byte 11. The 42-bit value is the base followed by the extension.
- R7: The time sample in a record is the value of the time input in the cycle that byte 11 of the packet is accepted.
- R8: A record occupies three consecutive valid cycles with beat codes 0, 1 and 2, carrying the reference, the time sample and the slot address in that order. The slot address is the number of start-of-packet bytes seen earlier on that stream, modulo 2^16, zero-extended.
- R9: The four streams keep separate parse state, so byte-interleaved packets are parsed independently. When records of several streams are pending, the lowest-numbered stream is sent first, and one record is never split by another.
- R10: After reset no table entry is enabled and both output valids are low. Host writes set an entry's identifier, enable bit and route code.
- R11: Bytes of a stream that arrive after its 188th byte and before its next start-of-packet are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Input byte valid |
| inSop | input | 1 | Input byte is byte 0 of a packet |
| inStream | input | 2 | Stream tag of the input byte |
| inData | input | 8 | Input byte |
| tblWe | input | 1 | Identifier table write strobe |
| tblIdx | input | 6 | Table entry index to write |
| tblPid | input | 13 | Identifier for the entry |
| tblEnable | input | 1 | Entry enable bit |
| tblRoute | input | 2 | Entry route code |
| pcrWe | input | 1 | Clock-reference identifier write strobe |
| pcrSel | input | 2 | Stream whose reference identifier is written |
| pcrPid | input | 13 | Clock-reference identifier value |
| stcIn | input | 42 | Free-running system time input |
| outValid | output | 1 | Forwarded payload byte valid |
| outData | output | 8 | Forwarded payload byte |
| outStream | output | 2 | Stream of the forwarded byte |
| outRoute | output | 2 | Route code of the forwarded byte |
| recValid | output | 1 | Timestamp record beat valid |
| recBeat | output | 2 | Beat code: 0 reference, 1 time, 2 address |
| recStream | output | 2 | Stream the record belongs to |
| recData | output | 42 | Beat payload |

## Verification
The bench builds the block with its default parameters: four streams, 64 table entries, 188-byte packets and a 16-bit slot address. With these values, two streams can be interleaved so that their reference bytes complete on adjacent cycles, which exercises record arbitration. Overlapping table entries at indices 3 and 9 exercise lowest-index priority. Streams are also given clock-reference identifiers that the table routes as reference-only.

// File: rtl/tsf_pkg.sv
package tsf_pkg;

  typedef enum logic [1:0] {
    RT_VIDEO   = 2'd0,
    RT_AUDIO   = 2'd1,
    RT_SYSTEM  = 2'd2,
    RT_PCRONLY = 2'd3
  } route_e;

  // byte positions inside a packet; the decode depends on them
  localparam int POS_HDR1   = 1;
  localparam int POS_HDR2   = 2;
  localparam int POS_HDR3   = 3;
  localparam int POS_AFLEN  = 4;
  localparam int POS_FLAGS  = 5;
  localparam int POS_PCR0   = 6;
  localparam int POS_PCR5   = 11;
  localparam int MIN_AF_LEN = 8;

  typedef struct packed {
    logic   sop;
    logic   pcrShift;
    logic   pcrDone;
    logic   fwd;
    route_e route;
  } strobe_t;

endpackage

// File: rtl/tsf_pid_table.sv
module tsf_pid_table
  import tsf_pkg::*;
#(
  parameter int NUM_ENTRIES = 64,
  parameter int PID_W       = 13,
  localparam int IW = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             wrEn,
  input  logic [IW-1:0]    wrIdx,
  input  logic [PID_W-1:0] wrPid,
  input  logic             wrValid,
  input  logic [1:0]       wrRoute,
  input  logic [PID_W-1:0] lookPid,
  output logic             lookHit,
  output route_e           lookRoute
);

  logic   [NUM_ENTRIES-1:0] matchVec;
  route_e                   routeA [NUM_ENTRIES];

  for (genvar e = 0; e < NUM_ENTRIES; e++) begin : gEntry
    logic [PID_W-1:0] pidR;
    logic             validR;
    route_e           routeR;

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        pidR   <= '0;
        validR <= 1'b0;
        routeR <= RT_VIDEO;
      end else if (wrEn && wrIdx == IW'(e)) begin
        pidR   <= wrPid;
        validR <= wrValid;
        routeR <= route_e'(wrRoute);
      end
    end

    assign matchVec[e] = validR && (pidR == lookPid);
    assign routeA[e]   = routeR;
  end

  logic [IW-1:0] selIdx;
  always_comb begin
    selIdx = '0;
    for (int i = NUM_ENTRIES - 1; i >= 0; i--) begin
      if (matchVec[i]) selIdx = IW'(i);
    end
  end

  assign lookHit   = |matchVec;
  assign lookRoute = routeA[selIdx];

  logic [NUM_ENTRIES-1:0] belowSel;
  always_comb begin
    for (int i = 0; i < NUM_ENTRIES; i++) belowSel[i] = (IW'(i) < selIdx);
  end

  AST_HIT_IS_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    lookHit |-> matchVec[selIdx]) else $error("hit without matching entry"); // R1
  AST_LOWEST_WINS: assert property (@(posedge clk) disable iff (!rstN)
    lookHit |-> ((matchVec & belowSel) == '0)) else $error("lower entry skipped"); // R2

endmodule

// File: rtl/tsf_ctrl.sv
module tsf_ctrl
  import tsf_pkg::*;
#(
  parameter int NUM_STREAMS = 4,
  parameter int PKT_LEN     = 188,
  parameter int PID_W       = 13,
  localparam int SW = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1,
  localparam int CW = $clog2(PKT_LEN + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inSop,
  input  logic [SW-1:0]    inStream,
  input  logic [7:0]       inData,
  input  logic             pcrWe,
  input  logic [SW-1:0]    pcrSel,
  input  logic [PID_W-1:0] pcrPidIn,
  output logic [PID_W-1:0] lookPid,
  input  logic             lookHit,
  input  route_e           lookRoute,
  output strobe_t          stb
);

  logic   [CW-1:0]    cntA      [NUM_STREAMS];
  logic               teiA      [NUM_STREAMS];
  logic               hitA      [NUM_STREAMS];
  logic               pcrOkA    [NUM_STREAMS];
  logic   [CW:0]      payStartA [NUM_STREAMS];
  logic   [PID_W-9:0] pidHiA    [NUM_STREAMS];
  route_e             routeA    [NUM_STREAMS];

  logic    [CW-1:0] idx;
  logic             active;
  logic             hitCur, teiCur, pcrOkCur;
  route_e           routeCur;
  logic    [CW:0]   payStartCur;

  assign hitCur      = hitA[inStream];
  assign teiCur      = teiA[inStream];
  assign pcrOkCur    = pcrOkA[inStream];
  assign routeCur    = routeA[inStream];
  assign payStartCur = payStartA[inStream];
  assign idx         = inSop ? '0 : cntA[inStream];
  assign active      = inValid && (inSop || cntA[inStream] < CW'(PKT_LEN));
  assign lookPid     = {pidHiA[inStream], inData};

  for (genvar g = 0; g < NUM_STREAMS; g++) begin : gStream
    logic   [CW-1:0]    cnt;
    logic               tei, hit, isPcr, pcrOk;
    logic   [PID_W-9:0] pidHi;
    logic   [1:0]       afc;
    logic   [CW:0]      payStart;
    logic   [PID_W-1:0] pcrPidR;
    route_e             route;
    logic               sel;

    assign sel = active && (inStream == SW'(g));

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        cnt      <= CW'(PKT_LEN);
        tei      <= 1'b0;
        hit      <= 1'b0;
        isPcr    <= 1'b0;
        pcrOk    <= 1'b0;
        pidHi    <= '0;
        afc      <= '0;
        payStart <= '1;
        pcrPidR  <= '0;
        route    <= RT_VIDEO;
      end else begin
        if (pcrWe && pcrSel == SW'(g)) pcrPidR <= pcrPidIn;
        if (sel) begin
          cnt <= idx + CW'(1);
          if (idx == '0) begin
            hit      <= 1'b0;
            pcrOk    <= 1'b0;
            payStart <= '1;
          end
          if (idx == CW'(POS_HDR1)) begin
            tei   <= inData[7];
            pidHi <= inData[PID_W-9:0];
          end
          if (idx == CW'(POS_HDR2)) begin
            hit   <= lookHit;
            route <= lookRoute;
            isPcr <= lookHit && ({pidHi, inData} == pcrPidR);
          end
          if (idx == CW'(POS_HDR3)) begin
            afc      <= inData[5:4];
            payStart <= (inData[5:4] == 2'b01) ? (CW+1)'(POS_AFLEN) : '1;
            pcrOk    <= isPcr && !tei && inData[5];
          end
          if (idx == CW'(POS_AFLEN)) begin
            if (afc == 2'b11) payStart <= (CW+1)'(POS_FLAGS) + (CW+1)'(inData);
            if (inData < 8'(MIN_AF_LEN)) pcrOk <= 1'b0;
          end
          if (idx == CW'(POS_FLAGS) && !inData[4]) pcrOk <= 1'b0;
        end
      end
    end

    assign cntA[g]      = cnt;
    assign teiA[g]      = tei;
    assign hitA[g]      = hit;
    assign pcrOkA[g]    = pcrOk;
    assign payStartA[g] = payStart;
    assign pidHiA[g]    = pidHi;
    assign routeA[g]    = route;
  end

  always_comb begin
    stb.sop      = active && (idx == '0);
    stb.pcrShift = active && pcrOkCur && (idx >= CW'(POS_PCR0)) && (idx <= CW'(POS_PCR5));
    stb.pcrDone  = stb.pcrShift && (idx == CW'(POS_PCR5));
    stb.fwd      = active && hitCur && !teiCur && (routeCur != RT_PCRONLY)
                   && (idx >= CW'(POS_AFLEN)) && ({1'b0, idx} >= payStartCur);
    stb.route    = routeCur;
  end

  AST_PCR_NOT_PAYLOAD: assert property (@(posedge clk) disable iff (!rstN)
    stb.pcrShift |-> !stb.fwd) else $error("reference byte forwarded"); // R6
  AST_PCR_NEEDS_CLEAN_HIT: assert property (@(posedge clk) disable iff (!rstN)
    stb.pcrDone |-> (hitCur && !teiCur)) else $error("record from rejected packet"); // R5

endmodule

// File: rtl/tsf_datapath.sv
module tsf_datapath
  import tsf_pkg::*;
#(
  parameter int NUM_STREAMS = 4,
  parameter int TS_W        = 42,
  parameter int ADDR_W      = 16,
  localparam int SW = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         stb,
  input  logic [SW-1:0]   inStream,
  input  logic [7:0]      inData,
  input  logic [TS_W-1:0] stcIn,
  output logic            outValid,
  output logic [7:0]      outData,
  output logic [SW-1:0]   outStream,
  output logic [1:0]      outRoute,
  output logic            recValid,
  output logic [1:0]      recBeat,
  output logic [SW-1:0]   recStream,
  output logic [TS_W-1:0] recData
);

  logic [NUM_STREAMS-1:0] pendA;
  logic [NUM_STREAMS-1:0] clrPend;
  logic [TS_W-1:0]        pcrA [NUM_STREAMS];
  logic [TS_W-1:0]        stcA [NUM_STREAMS];
  logic [ADDR_W-1:0]      adrA [NUM_STREAMS];

  logic            busy;
  logic [1:0]      beat;
  logic [SW-1:0]   cur;
  logic [SW-1:0]   pick;
  logic            anyPend;

  for (genvar g = 0; g < NUM_STREAMS; g++) begin : gSlot
    logic [39:0]       sh;
    logic [47:0]       full;
    logic [ADDR_W-1:0] nextAddr, curAddr, adrV;
    logic [TS_W-1:0]   pcrV, stcV;
    logic              pend, isMe;

    assign isMe = (inStream == SW'(g));
    assign full = {sh, inData};

    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        sh       <= '0;
        nextAddr <= '0;
        curAddr  <= '0;
        adrV     <= '0;
        pcrV     <= '0;
        stcV     <= '0;
        pend     <= 1'b0;
      end else begin
        if (isMe && stb.sop) begin
          curAddr  <= nextAddr;
          nextAddr <= nextAddr + ADDR_W'(1);
        end
        if (isMe && stb.pcrShift) sh <= {sh[31:0], inData};
        if (isMe && stb.pcrDone) begin
          pend <= 1'b1;
          pcrV <= TS_W'({full[47:15], full[8:0]});
          stcV <= stcIn;
          adrV <= curAddr;
        end else if (clrPend[g]) begin
          pend <= 1'b0;
        end
      end
    end

    assign pendA[g]   = pend;
    assign pcrA[g]    = pcrV;
    assign stcA[g]    = stcV;
    assign adrA[g]    = adrV;
    assign clrPend[g] = !busy && anyPend && (pick == SW'(g));
  end

  always_comb begin
    pick    = '0;
    anyPend = 1'b0;
    for (int i = NUM_STREAMS - 1; i >= 0; i--) begin
      if (pendA[i]) begin
        pick    = SW'(i);
        anyPend = 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      beat      <= '0;
      cur       <= '0;
      recValid  <= 1'b0;
      recBeat   <= '0;
      recStream <= '0;
      recData   <= '0;
    end else begin
      recValid <= 1'b0;
      if (!busy) begin
        if (anyPend) begin
          busy      <= 1'b1;
          cur       <= pick;
          beat      <= 2'd1;
          recValid  <= 1'b1;
          recBeat   <= 2'd0;
          recStream <= pick;
          recData   <= pcrA[pick];
        end
      end else begin
        recValid  <= 1'b1;
        recBeat   <= beat;
        recStream <= cur;
        recData   <= (beat == 2'd1) ? stcA[cur] : TS_W'(adrA[cur]);
        beat      <= beat + 2'd1;
        if (beat == 2'd2) busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      outData   <= '0;
      outStream <= '0;
      outRoute  <= '0;
    end else begin
      outValid  <= stb.fwd;
      outData   <= inData;
      outStream <= inStream;
      outRoute  <= stb.route;
    end
  end

  AST_BEAT_SEQUENCE: assert property (@(posedge clk) disable iff (!rstN)
    (recValid && recBeat != 2'd0) |-> ($past(recValid) && $past(recBeat) == recBeat - 2'd1
                                       && $past(recStream) == recStream))
    else $error("record beat out of order"); // R8
  AST_BEAT_CONTINUES: assert property (@(posedge clk) disable iff (!rstN)
    (recValid && recBeat < 2'd2) |=> (recValid && $stable(recStream)))
    else $error("record split"); // R9
  AST_BEAT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    recValid |-> (recBeat != 2'd3)) else $error("illegal beat code"); // R8

endmodule

// File: rtl/tsf_pid_pcr_filter.sv
module tsf_pid_pcr_filter
  import tsf_pkg::*;
#(
  parameter int NUM_STREAMS = 4,
  parameter int NUM_ENTRIES = 64,
  parameter int PKT_LEN     = 188,
  parameter int PID_W       = 13,
  parameter int TS_W        = 42,
  parameter int ADDR_W      = 16,
  localparam int SW = (NUM_STREAMS > 1) ? $clog2(NUM_STREAMS) : 1,
  localparam int IW = $clog2(NUM_ENTRIES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             inValid,
  input  logic             inSop,
  input  logic [SW-1:0]    inStream,
  input  logic [7:0]       inData,
  input  logic             tblWe,
  input  logic [IW-1:0]    tblIdx,
  input  logic [PID_W-1:0] tblPid,
  input  logic             tblEnable,
  input  logic [1:0]       tblRoute,
  input  logic             pcrWe,
  input  logic [SW-1:0]    pcrSel,
  input  logic [PID_W-1:0] pcrPid,
  input  logic [TS_W-1:0]  stcIn,
  output logic             outValid,
  output logic [7:0]       outData,
  output logic [SW-1:0]    outStream,
  output logic [1:0]       outRoute,
  output logic             recValid,
  output logic [1:0]       recBeat,
  output logic [SW-1:0]    recStream,
  output logic [TS_W-1:0]  recData
);

  logic [PID_W-1:0] lookPid;
  logic             lookHit;
  route_e           lookRoute;
  strobe_t          stb;

  tsf_pid_table #(.NUM_ENTRIES(NUM_ENTRIES), .PID_W(PID_W)) uTable (
    .clk(clk), .rstN(rstN),
    .wrEn(tblWe), .wrIdx(tblIdx), .wrPid(tblPid), .wrValid(tblEnable), .wrRoute(tblRoute),
    .lookPid(lookPid), .lookHit(lookHit), .lookRoute(lookRoute)
  );

  tsf_ctrl #(.NUM_STREAMS(NUM_STREAMS), .PKT_LEN(PKT_LEN), .PID_W(PID_W)) uCtrl (
    .clk(clk), .rstN(rstN),
    .inValid(inValid), .inSop(inSop), .inStream(inStream), .inData(inData),
    .pcrWe(pcrWe), .pcrSel(pcrSel), .pcrPidIn(pcrPid),
    .lookPid(lookPid), .lookHit(lookHit), .lookRoute(lookRoute),
    .stb(stb)
  );

  tsf_datapath #(.NUM_STREAMS(NUM_STREAMS), .TS_W(TS_W), .ADDR_W(ADDR_W)) uData (
    .clk(clk), .rstN(rstN),
    .stb(stb), .inStream(inStream), .inData(inData), .stcIn(stcIn),
    .outValid(outValid), .outData(outData), .outStream(outStream), .outRoute(outRoute),
    .recValid(recValid), .recBeat(recBeat), .recStream(recStream), .recData(recData)
  );

endmodule

// File: tb/tb_tsf_pid_pcr_filter.sv
module tb_tsf_pid_pcr_filter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0, inSop = 1'b0;
  logic [1:0]  inStream = '0;
  logic [7:0]  inData = '0;
  logic        tblWe = 1'b0, tblEnable = 1'b0;
  logic [5:0]  tblIdx = '0;
  logic [12:0] tblPid = '0, pcrPid = '0;
  logic [1:0]  tblRoute = '0, pcrSel = '0;
  logic        pcrWe = 1'b0;
  logic [41:0] stc = 42'h3_0000_0000;
  logic        outValid, recValid;
  logic [7:0]  outData;
  logic [1:0]  outStream, outRoute, recBeat, recStream;
  logic [41:0] recData;

  tsf_pid_pcr_filter dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inSop(inSop), .inStream(inStream), .inData(inData),
    .tblWe(tblWe), .tblIdx(tblIdx), .tblPid(tblPid), .tblEnable(tblEnable), .tblRoute(tblRoute),
    .pcrWe(pcrWe), .pcrSel(pcrSel), .pcrPid(pcrPid), .stcIn(stc),
    .outValid(outValid), .outData(outData), .outStream(outStream), .outRoute(outRoute),
    .recValid(recValid), .recBeat(recBeat), .recStream(recStream), .recData(recData)
  );

  always #4 clk = ~clk;
  always @(negedge clk) stc <= stc + 42'd3;

  int vectors = 0, fails = 0;
  logic [7:0]  pk [0:3][0:187];
  int          sopCnt [0:3];
  logic [41:0] expStc [0:3];
  int          expAddr [0:3];
  int          fwdCnt [0:3];
  int          fwdSum [0:3];
  int          fwdRoute [0:3];
  int          recN = 0;
  logic [1:0]  logS [0:15];
  logic [1:0]  logB [0:15];
  logic [41:0] logD [0:15];

  always @(negedge clk) begin
    if (outValid) begin
      fwdCnt[outStream]   = fwdCnt[outStream] + 1;
      fwdSum[outStream]   = fwdSum[outStream] + int'(outData);
      fwdRoute[outStream] = int'(outRoute);
    end
    if (recValid && recN < 16) begin
      logS[recN] = recStream;
      logB[recN] = recBeat;
      logD[recN] = recData;
      recN = recN + 1;
    end
  end

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clearMon();
    for (int s = 0; s < 4; s++) begin
      fwdCnt[s] = 0; fwdSum[s] = 0; fwdRoute[s] = -1;
    end
    recN = 0;
  endtask

  task automatic tblWrite(int idx, logic [12:0] pid, bit en, int route);
    @(negedge clk);
    tblWe = 1'b1; tblIdx = 6'(idx); tblPid = pid; tblEnable = en; tblRoute = 2'(route);
    @(negedge clk);
    tblWe = 1'b0;
  endtask

  task automatic pcrSet(int s, logic [12:0] pid);
    @(negedge clk);
    pcrWe = 1'b1; pcrSel = 2'(s); pcrPid = pid;
    @(negedge clk);
    pcrWe = 1'b0;
  endtask

  task automatic build(int s, logic [12:0] pid, bit tei, logic [1:0] afc, int afLen,
                       bit pflag, logic [32:0] base, logic [8:0] ext, int seed);
    for (int i = 0; i < 188; i++) pk[s][i] = 8'(i * 7 + seed);
    pk[s][0] = 8'h47;
    pk[s][1] = {tei, 1'b1, 1'b1, pid[12:8]};
    pk[s][2] = pid[7:0];
    pk[s][3] = {2'b00, afc, 4'h5};
    if (afc[1]) begin
      pk[s][4]  = 8'(afLen);
      pk[s][5]  = {3'b000, pflag, 4'b0000};
      pk[s][6]  = base[32:25];
      pk[s][7]  = base[24:17];
      pk[s][8]  = base[16:9];
      pk[s][9]  = base[8:1];
      pk[s][10] = {base[0], 6'h3F, ext[8]};
      pk[s][11] = ext[7:0];
    end
  endtask

  function automatic int startOf(logic [1:0] afc, int afLen);
    if (afc == 2'b01) return 4;
    if (afc == 2'b11) return 5 + afLen;
    return 188;
  endfunction

  function automatic int expSum(int s, int start);
    int sum = 0;
    for (int i = start; i < 188; i++) sum += int'(pk[s][i]);
    return sum;
  endfunction

  task automatic driveByte(int s, int i);
    @(negedge clk);
    inValid = 1'b1; inSop = (i == 0); inStream = 2'(s);
    inData = (i < 188) ? pk[s][i] : 8'hA5;
    if (i == 0) begin expAddr[s] = sopCnt[s]; sopCnt[s]++; end
    if (i == 11) begin #1; expStc[s] = stc; end
  endtask

  task automatic idle(int n);
    @(negedge clk);
    inValid = 1'b0; inSop = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic sendPkt(int s, int extra);
    for (int i = 0; i < 188 + extra; i++) driveByte(s, i);
    idle(12);
  endtask

  task automatic sendPair(int a, int b);
    for (int i = 0; i < 188; i++) begin
      driveByte(a, i);
      driveByte(b, i);
    end
    idle(16);
  endtask

  task automatic t_reset();
    chk("R10 outValid in reset", 64'(outValid), 0);
    chk("R10 recValid in reset", 64'(recValid), 0);
    @(negedge clk); rstN = 1'b1;
    repeat (2) @(negedge clk);
    clearMon();
    build(0, 13'h0100, 0, 2'b01, 0, 0, 0, 0, 3);
    sendPkt(0, 0);
    chk("R10 empty table forwards nothing", 64'(fwdCnt[0]), 0);
  endtask

  task automatic t_basic();
    tblWrite(5, 13'h0100, 1, 0);
    clearMon();
    build(0, 13'h0100, 0, 2'b01, 0, 0, 0, 0, 11);
    sendPkt(0, 10);
    chk("R4 R11 payload count", 64'(fwdCnt[0]), 184);
    chk("R4 payload sum", 64'(fwdSum[0]), 64'(expSum(0, 4)));
    chk("R1 R4 route tag", 64'(fwdRoute[0]), 0);
    clearMon();
    build(0, 13'h1100, 0, 2'b01, 0, 0, 0, 0, 11);
    sendPkt(0, 0);
    chk("R1 pid bit12 differs", 64'(fwdCnt[0]), 0);
  endtask

  task automatic t_prio();
    tblWrite(9, 13'h0200, 1, 2);
    tblWrite(3, 13'h0200, 1, 1);
    clearMon();
    build(1, 13'h0200, 0, 2'b01, 0, 0, 0, 0, 21);
    sendPkt(1, 0);
    chk("R2 lowest index route", 64'(fwdRoute[1]), 1);
    tblWrite(3, 13'h0200, 0, 1);
    clearMon();
    sendPkt(1, 0);
    chk("R2 R10 after disable", 64'(fwdRoute[1]), 2);
    chk("R2 count after disable", 64'(fwdCnt[1]), 184);
  endtask

  task automatic t_tei();
    clearMon();
    build(0, 13'h0100, 1, 2'b01, 0, 0, 0, 0, 5);
    sendPkt(0, 0);
    chk("R3 error flag blocks payload", 64'(fwdCnt[0]), 0);
  endtask

  task automatic t_adapt();
    clearMon();
    build(0, 13'h0100, 0, 2'b11, 10, 0, 0, 0, 9);
    sendPkt(0, 0);
    chk("R4 adaptation then payload count", 64'(fwdCnt[0]), 64'(188 - startOf(2'b11, 10)));
    chk("R4 adaptation then payload sum", 64'(fwdSum[0]), 64'(expSum(0, 15)));
    chk("R5 no record for non-reference pid", 64'(recN), 0);
    clearMon();
    build(0, 13'h0100, 0, 2'b10, 183, 0, 0, 0, 9);
    sendPkt(0, 0);
    chk("R4 adaptation only", 64'(fwdCnt[0]), 0);
  endtask

  task automatic t_pcr();
    logic [32:0] base = 33'h1_2345_6789;
    logic [8:0]  ext  = 9'h155;
    pcrSet(1, 13'h0321);
    tblWrite(7, 13'h0321, 1, 3);
    clearMon();
    build(1, 13'h0321, 0, 2'b10, 183, 1, base, ext, 2);
    sendPkt(1, 0);
    chk("R8 three beats", 64'(recN), 3);
    chk("R8 beat0 code", 64'(logB[0]), 0);
    chk("R6 reference value", 64'(logD[0]), 64'({base, ext}));
    chk("R8 beat1 code", 64'(logB[1]), 1);
    chk("R7 time sample", 64'(logD[1]), 64'(expStc[1]));
    chk("R8 beat2 address", 64'(logD[2]), 64'(expAddr[1]));
    chk("R8 stream tag", 64'(logS[2]), 1);
    chk("R4 reference-only forwards nothing", 64'(fwdCnt[1]), 0);
    clearMon();
    build(1, 13'h0321, 0, 2'b11, 8, 1, 33'h0_0000_0001, 9'h1FF, 4);
    sendPkt(1, 0);
    chk("R5 length 8 accepted", 64'(recN), 3);
    chk("R6 low base and full extension", 64'(logD[0]), 64'({33'h1, 9'h1FF}));
    chk("R8 address advances", 64'(logD[2]), 64'(expAddr[1]));
  endtask

  task automatic t_pcrReject();
    clearMon();
    build(1, 13'h0321, 0, 2'b11, 7, 1, 33'h5, 9'h5, 1);
    sendPkt(1, 0);
    chk("R5 length 7 rejected", 64'(recN), 0);
    build(1, 13'h0321, 0, 2'b11, 20, 0, 33'h5, 9'h5, 1);
    sendPkt(1, 0);
    chk("R5 flag clear rejected", 64'(recN), 0);
    build(1, 13'h0321, 0, 2'b01, 0, 1, 33'h5, 9'h5, 1);
    sendPkt(1, 0);
    chk("R5 no adaptation rejected", 64'(recN), 0);
    build(1, 13'h0321, 1, 2'b10, 183, 1, 33'h5, 9'h5, 1);
    sendPkt(1, 0);
    chk("R3 error flag blocks record", 64'(recN), 0);
    build(0, 13'h0321, 0, 2'b10, 183, 1, 33'h5, 9'h5, 1);
    sendPkt(0, 0);
    chk("R5 other stream reference pid differs", 64'(recN), 0);
    tblWrite(7, 13'h0321, 0, 3);
    build(1, 13'h0321, 0, 2'b10, 183, 1, 33'h5, 9'h5, 1);
    sendPkt(1, 0);
    chk("R10 disabled entry gives no record", 64'(recN), 0);
  endtask

  task automatic t_interleave();
    logic [32:0] bA = 33'h0_ABCD_0123;
    logic [32:0] bB = 33'h1_0F0F_F0F0;
    pcrSet(2, 13'h0400);
    pcrSet(3, 13'h0400);
    tblWrite(12, 13'h0400, 1, 0);
    clearMon();
    build(3, 13'h0400, 0, 2'b11, 20, 1, bB, 9'h0AA, 17);
    build(2, 13'h0400, 0, 2'b11, 20, 1, bA, 9'h101, 33);
    sendPair(2, 3);
    chk("R9 six beats", 64'(recN), 6);
    chk("R9 first record stream", 64'(logS[0]), 2);
    chk("R9 first reference", 64'(logD[0]), 64'({bA, 9'h101}));
    chk("R9 first time", 64'(logD[1]), 64'(expStc[2]));
    chk("R9 first record unsplit", 64'(logS[2]), 2);
    chk("R9 second record stream", 64'(logS[3]), 3);
    chk("R9 second beat code", 64'(logB[3]), 0);
    chk("R9 second reference", 64'(logD[3]), 64'({bB, 9'h0AA}));
    chk("R9 second time", 64'(logD[4]), 64'(expStc[3]));
    chk("R9 second address", 64'(logD[5]), 64'(expAddr[3]));
    chk("R9 stream2 payload", 64'(fwdCnt[2]), 163);
    chk("R9 stream3 payload sum", 64'(fwdSum[3]), 64'(expSum(3, 25)));
  endtask

  initial begin
    for (int s = 0; s < 4; s++) sopCnt[s] = 0;
    clearMon();
    repeat (3) @(negedge clk);
    t_reset();
    t_basic();
    t_prio();
    t_tei();
    t_adapt();
    t_pcr();
    t_pcrReject();
    t_interleave();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

endmodule